// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the register-facing half of a three-channel interval timer. A host on a synchronous 8-bit bus programs each counting channel through one write-only control register and reads or loads each channel's 16-bit value through that channel's own byte-wide data address. For every channel the block holds the programmed operating mode, the BCD flag and the byte access pattern. It assembles initial counts from byte writes and reports when a new count is complete. When a two-byte load is only half written, it reports that too, so the counting core can stop and restart.

The counting cores themselves sit outside this block. Each core presents its live count back on `live_cnt`, and the block serves byte reads of that value. A latch command freezes a snapshot of one channel for a consistent two-byte read while the core keeps counting. Register addresses 0 to 2 select channels 0 to 2, and address 3 is the control register.

Top module: `ptimer_regif`

## Requirements
- R1: After reset every channel has mode 0, BCD flag 0, count 0x0000, no pulse outputs asserted, and `bus_rdata` is 0x00.
- R2: A write to address 3 whose access field is not 00 programs the channel named by bits 7:6. Bits 5:4 give the access pattern, bits 3:1 give the mode and bit 0 gives the BCD flag. The new mode and flag appear in the cycle after the write, together with a one-cycle `ch_ctl_wr` pulse for that channel.
- R3: A control write with bits 7:6 equal to 3 changes no mode, flag or count and produces no pulse.
- R4: With access pattern 01 (low byte only), a data write loads the count {0x00, byte} and pulses `ch_load` for one cycle.
- R5: With access pattern 10 (high byte only), a data write loads the count {byte, 0x00} and pulses `ch_load`.
- R6: With access pattern 11, the first data write pulses `ch_stop` and leaves the count unchanged. The second data write loads {second byte, first byte} and pulses `ch_load`.
- R7: Data writes never change a channel's mode or BCD flag.
- R8: Until a channel has been programmed by a control byte (access pattern 00 state after reset), its data writes are ignored and its reads return 0x00.
- R9: A read returns a byte of the live count one cycle later. Pattern 01 returns the low byte, pattern 10 returns the high byte, and pattern 11 alternates between low and high bytes, starting with the low byte.
- R10: A control write with access field 00 snapshots that channel's live count. The following reads return the snapshot, low byte first in pattern 11. The latch is released after the last byte of the pattern has been read, and the mode is left unchanged.
- R11: A latch command to a channel whose snapshot has not yet been fully read is ignored.
- R12: A programming control write clears that channel's pending latch, its read byte toggle and its write byte toggle.
- R13: `bus_rdata` changes only in the cycle after a read strobe. A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| live_cnt | input | NCH*16 | Live count of each channel, channel 0 in the low bits |
| ch_mode | output | NCH*3 | Programmed operating mode per channel |
| ch_bcd | output | NCH | Programmed BCD flag per channel |
| ch_count | output | NCH*16 | Assembled initial count per channel |
| ch_ctl_wr | output | NCH | One-cycle pulse when a channel is programmed |
| ch_stop | output | NCH | One-cycle pulse on the first byte of a two-byte load |
| ch_load | output | NCH | One-cycle pulse when a complete count has been loaded |

## Verification
On every cycle, the embedded assertions check that counts, modes and read data hold still unless a matching strobe arrives. They also check that single-byte loads zero the other byte, that a stop pulse only appears in two-byte access, that a pending snapshot survives until it is read out, and that an illegal channel select leaves the programming untouched. Byte ordering across several bus cycles can only be shown by the bench's scenarios, which compare against a behavioural model on each clock. These cover alternating reads, a latch ignored while pending, toggles reset by reprogramming, and a latch value that differs from the moving live count.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

   // byte access pattern; value 0 doubles as "latch command" / "unprogrammed"
   typedef enum logic [1:0] {
      ACC_LATCH = 2'd0,
      ACC_LO    = 2'd1,
      ACC_HI    = 2'd2,
      ACC_BOTH  = 2'd3
   } acc_e;

   localparam logic [1:0] CTL_ADDR  = 2'd3;
   localparam logic [1:0] SEL_BAD   = 2'd3;
   localparam int         MODE_W    = 3;

endpackage

// File: rtl/ptimer_ctl_dec.sv
module ptimer_ctl_dec
   import ptimer_pkg::*;
#(
   parameter int NCH = 3,
   parameter int DW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DW-1:0]     bus_wdata,
   output logic [NCH-1:0]    prog_stb,
   output logic [NCH-1:0]    latch_stb,
   output logic [NCH-1:0]    data_stb,
   output logic [NCH-1:0]    read_stb,
   output acc_e              f_acc,
   output logic [MODE_W-1:0] f_mode,
   output logic              f_bcd
);

   logic       ctl_hit;
   logic [1:0] tgt;

   assign ctl_hit = bus_wr && (bus_sel == CTL_ADDR);
   assign tgt     = bus_wdata[7:6];
   assign f_acc   = acc_e'(bus_wdata[5:4]);
   assign f_mode  = bus_wdata[3:1];
   assign f_bcd   = bus_wdata[0];

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign prog_stb[g]  = ctl_hit && (tgt == 2'(g)) && (f_acc != ACC_LATCH);
      assign latch_stb[g] = ctl_hit && (tgt == 2'(g)) && (f_acc == ACC_LATCH);
      assign data_stb[g]  = bus_wr && (bus_sel == 2'(g));
      assign read_stb[g]  = bus_rd && (bus_sel == 2'(g));
   end

   // R2
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prog_stb, latch_stb, data_stb}));

endmodule

// File: rtl/ptimer_wr_chan.sv
module ptimer_wr_chan
   import ptimer_pkg::*;
#(
   parameter int DW = 8,
   localparam int CW = 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_stb,
   input  logic              data_stb,
   input  acc_e              f_acc,
   input  logic [MODE_W-1:0] f_mode,
   input  logic              f_bcd,
   input  logic [DW-1:0]     wdata,
   output acc_e              acc,
   output logic [MODE_W-1:0] mode,
   output logic              bcd,
   output logic [CW-1:0]     count,
   output logic              ctl_p,
   output logic              stop_p,
   output logic              load_p
);

   logic [DW-1:0] lo_buf;
   logic          wtog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= ACC_LATCH;
         mode   <= '0;
         bcd    <= 1'b0;
         count  <= '0;
         lo_buf <= '0;
         wtog   <= 1'b0;
         ctl_p  <= 1'b0;
         stop_p <= 1'b0;
         load_p <= 1'b0;
      end else begin
         ctl_p  <= 1'b0;
         stop_p <= 1'b0;
         load_p <= 1'b0;
         if (prog_stb) begin
            acc   <= f_acc;
            mode  <= f_mode;
            bcd   <= f_bcd;
            wtog  <= 1'b0;
            ctl_p <= 1'b1;
         end else if (data_stb) begin
            unique case (acc)
               ACC_LO: begin
                  count  <= {{DW{1'b0}}, wdata};
                  load_p <= 1'b1;
               end
               ACC_HI: begin
                  count  <= {wdata, {DW{1'b0}}};
                  load_p <= 1'b1;
               end
               ACC_BOTH: begin
                  if (!wtog) begin
                     lo_buf <= wdata;
                     wtog   <= 1'b1;
                     stop_p <= 1'b1;
                  end else begin
                     count  <= {wdata, lo_buf};
                     wtog   <= 1'b0;
                     load_p <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R4
   lo_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_p && acc == ACC_LO) |-> (count[CW-1:DW] == '0));

   // R5
   hi_only_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_p && acc == ACC_HI) |-> (count[DW-1:0] == '0));

   // R6
   stop_two_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |-> (acc == ACC_BOTH && !load_p));

   // R7
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_p |-> $stable(count));

endmodule

// File: rtl/ptimer_rd_chan.sv
module ptimer_rd_chan
   import ptimer_pkg::*;
#(
   parameter int DW = 8,
   localparam int CW = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_stb,
   input  logic          latch_stb,
   input  logic          read_stb,
   input  acc_e          acc,
   input  logic [CW-1:0] live,
   output logic [DW-1:0] rd_byte
);

   logic          rtog;
   logic          held;
   logic [CW-1:0] snap;
   logic [CW-1:0] src;
   logic          hi_sel;
   logic          last_byte;

   assign src       = held ? snap : live;
   assign hi_sel    = (acc == ACC_HI) || (acc == ACC_BOTH && rtog);
   assign last_byte = (acc == ACC_LO) || (acc == ACC_HI) || (acc == ACC_BOTH && rtog);

   always_comb begin
      if (acc == ACC_LATCH) rd_byte = '0;
      else if (hi_sel)      rd_byte = src[CW-1:DW];
      else                  rd_byte = src[DW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rtog <= 1'b0;
         held <= 1'b0;
         snap <= '0;
      end else if (prog_stb) begin
         rtog <= 1'b0;
         held <= 1'b0;
      end else if (latch_stb) begin
         if (!held) begin
            held <= 1'b1;
            snap <= live;
            rtog <= 1'b0;
         end
      end else if (read_stb && acc != ACC_LATCH) begin
         if (acc == ACC_BOTH) rtog <= ~rtog;
         if (last_byte)       held <= 1'b0;
      end
   end

   // R10
   snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_stb && !held) |=> (held && snap == $past(live)));

   // R11
   snap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !read_stb && !prog_stb) |=> (held && $stable(snap)));

   // R12
   snap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_stb |=> !held);

endmodule

// File: rtl/ptimer_regif.sv
module ptimer_regif
   import ptimer_pkg::*;
#(
   parameter int NCH = 3,
   parameter int DW  = 8,
   localparam int CW = 2 * DW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            bus_sel,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic [NCH*CW-1:0]     live_cnt,
   output logic [NCH*MODE_W-1:0] ch_mode,
   output logic [NCH-1:0]        ch_bcd,
   output logic [NCH*CW-1:0]     ch_count,
   output logic [NCH-1:0]        ch_ctl_wr,
   output logic [NCH-1:0]        ch_stop,
   output logic [NCH-1:0]        ch_load
);

   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("ptimer_regif: NCH must be 1..3");
   end
   if (DW != 8) begin : g_bad_dw
      $error("ptimer_regif: control byte layout needs DW == 8");
   end

   logic [NCH-1:0]    prog_stb, latch_stb, data_stb, read_stb;
   acc_e              f_acc;
   logic [MODE_W-1:0] f_mode;
   logic              f_bcd;
   logic [DW-1:0]     rd_byte [NCH];
   logic [DW-1:0]     rd_nxt;

   ptimer_ctl_dec #(.NCH(NCH), .DW(DW)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .prog_stb  (prog_stb),
      .latch_stb (latch_stb),
      .data_stb  (data_stb),
      .read_stb  (read_stb),
      .f_acc     (f_acc),
      .f_mode    (f_mode),
      .f_bcd     (f_bcd)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      acc_e acc_w;

      ptimer_wr_chan #(.DW(DW)) u_wr (
         .clk      (clk),
         .rst_n    (rst_n),
         .prog_stb (prog_stb[g]),
         .data_stb (data_stb[g]),
         .f_acc    (f_acc),
         .f_mode   (f_mode),
         .f_bcd    (f_bcd),
         .wdata    (bus_wdata),
         .acc      (acc_w),
         .mode     (ch_mode[g*MODE_W +: MODE_W]),
         .bcd      (ch_bcd[g]),
         .count    (ch_count[g*CW +: CW]),
         .ctl_p    (ch_ctl_wr[g]),
         .stop_p   (ch_stop[g]),
         .load_p   (ch_load[g])
      );

      ptimer_rd_chan #(.DW(DW)) u_rd (
         .clk       (clk),
         .rst_n     (rst_n),
         .prog_stb  (prog_stb[g]),
         .latch_stb (latch_stb[g]),
         .read_stb  (read_stb[g]),
         .acc       (acc_w),
         .live      (live_cnt[g*CW +: CW]),
         .rd_byte   (rd_byte[g])
      );
   end

   always_comb begin
      rd_nxt = '0;
      for (int c = 0; c < NCH; c++) begin
         if (bus_sel == 2'(c)) rd_nxt = rd_byte[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_nxt;
   end

   // R3
   bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_sel == CTL_ADDR && bus_wdata[7:6] == SEL_BAD)
      |=> ($stable(ch_mode) && $stable(ch_bcd) && ch_ctl_wr == '0 && ch_load == '0));

   // R13
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R13
   ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_sel == CTL_ADDR) |=> (bus_rdata == '0));

   // R2
   ctl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_ctl_wr) && $onehot0(ch_load | ch_stop));

endmodule

// File: tb/ptimer_regif_test.sv
module ptimer_regif_test;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 3;
   localparam int DW  = 8;
   localparam int CW  = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       sel = '0;
   logic             wr = 1'b0, rd = 1'b0;
   logic [DW-1:0]    wdata = '0;
   logic [DW-1:0]    rdata;
   logic [NCH*CW-1:0] live_bus;
   logic [NCH*3-1:0] ch_mode;
   logic [NCH-1:0]   ch_bcd, ch_ctl_wr, ch_stop, ch_load;
   logic [NCH*CW-1:0] ch_count;

   logic [CW-1:0] base [NCH];
   logic          run = 1'b0;
   int unsigned   tick = 0;
   int            n_chk = 0, n_err = 0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int c = 0; c < NCH; c++)
         live_bus[c*CW +: CW] = base[c] - CW'(tick * (c + 1));
   end

   always @(posedge clk) if (run) tick <= tick + 1;

   ptimer_regif #(.NCH(NCH), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
      .bus_wdata(wdata), .bus_rdata(rdata), .live_cnt(live_bus),
      .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_count(ch_count),
      .ch_ctl_wr(ch_ctl_wr), .ch_stop(ch_stop), .ch_load(ch_load)
   );

   // ---------------- behavioural reference model ----------------
   int          m_acc  [NCH];
   int          m_mode [NCH];
   int          m_bcd  [NCH];
   int          m_cnt  [NCH];
   int          m_lo   [NCH];
   bit          m_wt   [NCH];
   bit          m_rt   [NCH];
   bit          m_lat  [NCH];
   int          m_snap [NCH];
   bit          m_ctl  [NCH];
   bit          m_stop [NCH];
   bit          m_load [NCH];
   int          m_rdata;

   function automatic int live_of(int c);
      return int'(live_bus[c*CW +: CW]);
   endfunction

   task automatic m_write(int s, int d);
      int tgt, acc;
      if (s == 3) begin
         tgt = d / 64;
         acc = (d / 16) % 4;
         if (tgt >= NCH) return;
         if (acc == 0) begin
            if (!m_lat[tgt]) begin
               m_lat[tgt] = 1; m_snap[tgt] = live_of(tgt); m_rt[tgt] = 0;
            end
         end else begin
            m_acc[tgt] = acc; m_mode[tgt] = (d / 2) % 8; m_bcd[tgt] = d % 2;
            m_wt[tgt] = 0; m_rt[tgt] = 0; m_lat[tgt] = 0; m_ctl[tgt] = 1;
         end
      end else if (s < NCH) begin
         case (m_acc[s])
            1: begin m_cnt[s] = d; m_load[s] = 1; end
            2: begin m_cnt[s] = d * 256; m_load[s] = 1; end
            3: if (!m_wt[s]) begin m_lo[s] = d; m_wt[s] = 1; m_stop[s] = 1; end
               else begin m_cnt[s] = d * 256 + m_lo[s]; m_wt[s] = 0; m_load[s] = 1; end
            default: ;
         endcase
      end
   endtask

   task automatic m_read(int s);
      int v;
      bit hi;
      if (s >= NCH || m_acc[s] == 0) begin m_rdata = 0; return; end
      v  = m_lat[s] ? m_snap[s] : live_of(s);
      hi = (m_acc[s] == 2) || (m_acc[s] == 3 && m_rt[s]);
      m_rdata = hi ? (v / 256) % 256 : v % 256;
      if (m_acc[s] != 3 || m_rt[s]) m_lat[s] = 0;
      if (m_acc[s] == 3) m_rt[s] = !m_rt[s];
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 0; m_mode[c] = 0; m_bcd[c] = 0; m_cnt[c] = 0; m_lo[c] = 0;
            m_wt[c] = 0; m_rt[c] = 0; m_lat[c] = 0; m_snap[c] = 0;
            m_ctl[c] = 0; m_stop[c] = 0; m_load[c] = 0;
         end
         m_rdata = 0;
      end else begin
         for (int c = 0; c < NCH; c++) begin m_ctl[c] = 0; m_stop[c] = 0; m_load[c] = 0; end
         if (wr) m_write(int'(sel), int'(wdata));
         if (rd) m_read(int'(sel));
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_model();
      for (int c = 0; c < NCH; c++) begin
         chk("R2", $sformatf("ch%0d mode", c), int'(ch_mode[c*3 +: 3]), m_mode[c]);
         chk("R2", $sformatf("ch%0d bcd", c), int'(ch_bcd[c]), m_bcd[c]);
         chk("R2", $sformatf("ch%0d ctl_wr", c), int'(ch_ctl_wr[c]), int'(m_ctl[c]));
         chk("R6", $sformatf("ch%0d count", c), int'(ch_count[c*CW +: CW]), m_cnt[c]);
         chk("R6", $sformatf("ch%0d stop", c), int'(ch_stop[c]), int'(m_stop[c]));
         chk("R6", $sformatf("ch%0d load", c), int'(ch_load[c]), int'(m_load[c]));
      end
      chk("R9", "rdata", int'(rdata), m_rdata);
   endtask

   task automatic op(input logic [1:0] s, input logic w, input logic r, input logic [7:0] d);
      sel = s; wr = w; rd = r; wdata = d;
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      if (rst_n) compare_model();
   endtask

   task automatic idle();
      op(2'd0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic rd_op(input logic [1:0] s);
      op(s, 1'b0, 1'b1, 8'h00);
   endtask

   task automatic set_live(int c, logic [CW-1:0] v);
      base[c] = v + CW'(tick * (c + 1));
   endtask

   function automatic int cnt_of(int c);
      return int'(ch_count[c*CW +: CW]);
   endfunction

   function automatic int mode_of(int c);
      return int'(ch_mode[c*3 +: 3]);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [NCH*3-1:0] mode_snap;
      for (int c = 0; c < NCH; c++) base[c] = 16'h1234;
      repeat (3) idle();
      rst_n = 1'b1;
      idle();

      // R1 reset state
      chk("R1", "mode all", int'(ch_mode), 0);
      chk("R1", "bcd all", int'(ch_bcd), 0);
      chk("R1", "count all", int'(ch_count), 0);
      chk("R1", "pulses", int'({ch_ctl_wr, ch_stop, ch_load}), 0);
      chk("R1", "rdata", int'(rdata), 0);

      // R8 unprogrammed channel
      op(2'd0, 1'b1, 1'b0, 8'h55);
      chk("R8", "unprog load", int'(ch_load), 0);
      chk("R8", "unprog count", cnt_of(0), 0);
      rd_op(2'd0);
      chk("R8", "unprog read", int'(rdata), 0);

      // R2 program ch1: low only, mode 3, bcd
      op(2'd3, 1'b1, 1'b0, 8'b01_01_011_1);
      chk("R2", "ch1 mode", mode_of(1), 3);
      chk("R2", "ch1 bcd", int'(ch_bcd[1]), 1);
      chk("R2", "ctl pulse", int'(ch_ctl_wr), 3'b010);

      // R4 low-only load
      op(2'd1, 1'b1, 1'b0, 8'h5A);
      chk("R4", "ch1 count", cnt_of(1), 16'h005A);
      chk("R4", "ch1 load", int'(ch_load), 3'b010);
      idle();
      chk("R4", "load one cycle", int'(ch_load), 0);

      // R5 high-only load on ch2
      op(2'd3, 1'b1, 1'b0, 8'b10_10_010_0);
      op(2'd2, 1'b1, 1'b0, 8'h33);
      chk("R5", "ch2 count", cnt_of(2), 16'h3300);

      // R6 two-byte load on ch0
      op(2'd3, 1'b1, 1'b0, 8'b00_11_000_0);
      op(2'd0, 1'b1, 1'b0, 8'h34);
      chk("R6", "first byte stop", int'(ch_stop), 3'b001);
      chk("R6", "first byte no load", int'(ch_load), 0);
      chk("R6", "first byte count", cnt_of(0), 0);
      op(2'd0, 1'b1, 1'b0, 8'h12);
      chk("R6", "second byte load", int'(ch_load), 3'b001);
      chk("R6", "assembled", cnt_of(0), 16'h1234);

      // R7 data write keeps mode
      op(2'd1, 1'b1, 1'b0, 8'hC3);
      chk("R7", "ch1 mode kept", mode_of(1), 3);
      chk("R7", "ch1 bcd kept", int'(ch_bcd[1]), 1);
      chk("R7", "ch1 count", cnt_of(1), 16'h00C3);

      // R3 illegal channel select
      mode_snap = ch_mode;
      op(2'd3, 1'b1, 1'b0, 8'b11_11_101_1);
      chk("R3", "modes kept", int'(ch_mode), int'(mode_snap));
      chk("R3", "no ctl pulse", int'(ch_ctl_wr), 0);

      // R9 live reads
      set_live(0, 16'hBEEF); set_live(1, 16'h4321); set_live(2, 16'h9876);
      rd_op(2'd0); chk("R9", "ch0 low", int'(rdata), 8'hEF);
      rd_op(2'd0); chk("R9", "ch0 high", int'(rdata), 8'hBE);
      rd_op(2'd1); chk("R9", "ch1 low", int'(rdata), 8'h21);
      rd_op(2'd1); chk("R9", "ch1 low again", int'(rdata), 8'h21);
      rd_op(2'd2); chk("R9", "ch2 high", int'(rdata), 8'h98);

      // R10 latch snapshot
      set_live(0, 16'hCAFE);
      op(2'd3, 1'b1, 1'b0, 8'b00_00_1111);
      set_live(0, 16'h1111);
      rd_op(2'd0); chk("R10", "snap low", int'(rdata), 8'hFE);
      chk("R10", "mode unchanged", mode_of(0), 0);
      rd_op(2'd0); chk("R10", "snap high", int'(rdata), 8'hCA);
      rd_op(2'd0); chk("R10", "released low", int'(rdata), 8'h11);
      rd_op(2'd0); chk("R10", "released high", int'(rdata), 8'h11);

      // R11 second latch ignored
      set_live(0, 16'hA1A2);
      op(2'd3, 1'b1, 1'b0, 8'b00_00_0000);
      set_live(0, 16'hB1B2);
      op(2'd3, 1'b1, 1'b0, 8'b00_00_0000);
      rd_op(2'd0); chk("R11", "first snap low", int'(rdata), 8'hA2);
      rd_op(2'd0); chk("R11", "first snap high", int'(rdata), 8'hA1);

      // R12 reprogramming clears latch and toggles
      set_live(0, 16'hC0C1);
      op(2'd3, 1'b1, 1'b0, 8'b00_00_0000);
      set_live(0, 16'hD0D1);
      op(2'd3, 1'b1, 1'b0, 8'b00_11_001_0);
      rd_op(2'd0); chk("R12", "latch cleared", int'(rdata), 8'hD1);
      chk("R12", "mode set", mode_of(0), 1);
      op(2'd3, 1'b1, 1'b0, 8'b00_11_001_0);
      rd_op(2'd0); chk("R12", "read toggle reset", int'(rdata), 8'hD1);
      op(2'd0, 1'b1, 1'b0, 8'h99);
      op(2'd3, 1'b1, 1'b0, 8'b00_11_001_0);
      op(2'd0, 1'b1, 1'b0, 8'h77);
      chk("R12", "write toggle reset stop", int'(ch_stop), 3'b001);
      op(2'd0, 1'b1, 1'b0, 8'h66);
      chk("R12", "count after reprogram", cnt_of(0), 16'h6677);

      // R13 control read and hold
      rd_op(2'd3); chk("R13", "control read", int'(rdata), 0);
      rd_op(2'd0); chk("R13", "data read", int'(rdata), 8'hD1);
      idle(); idle();
      chk("R13", "rdata held", int'(rdata), 8'hD1);

      // mixed traffic against the model, counters running
      run = 1'b1;
      for (int i = 0; i < 600; i++) begin
         int k;
         k = int'($urandom % 8);
         case (k)
            0:       op(2'd3, 1'b1, 1'b0, 8'($urandom));
            1, 2, 3: op(2'($urandom % 3), 1'b1, 1'b0, 8'($urandom));
            4, 5, 6: rd_op(2'($urandom % 4));
            default: idle();
         endcase
      end
      run = 1'b0;
      idle();
      finish_run();
   end

endmodule